// File: doc/BRIEF.md
# Serial Port Register Front End

This block is the register-facing half of a simple serial port. Software reaches it through a synchronous word-addressed port that has separate read and write strobes. The character side is modelled at byte level. A single-entry holding register takes received bytes through a valid/ready handshake. A line-break pulse loads a fixed code word into that same register. A write to the transmit address emits one byte for one cycle. One level-sensitive interrupt combines the receive-ready and transmit-ready conditions with their enables from the first control word.

Occupancy of the holding register is kept in a two-state machine. `HOLD_EMPTY` is the reset state. It moves to `HOLD_FULL` when a byte is accepted or a break arrives. `HOLD_FULL` stays in place on a further break, which overwrites the held value. It returns to `HOLD_EMPTY` on a read of the receive-data address or on a soft reset, and soft reset takes priority over everything else. Three status words report the state: two ready flags and one empty flag. All three are taken from this single machine, so they can never disagree.

Top module: `sio_regfile`

## Requirements
- R1: After reset, the first status word (address 0x25) reads 0x2000 and the second status word (0x26) reads 0x4008. The test word (0x2D) reads 0x20, the first control word (0x20) reads 0x1, the rate registers read 0, and the receive-data address (0x00) reads 0x8000.
- R2: `rx_ready` is high exactly when no character is held. A byte accepted with `rx_valid` and `rx_ready` makes the first status word 0x2200, the second 0x4009 and the test word 0. A byte offered while a character is held is not taken.
- R3: A read of address 0x00 returns the held value with bit 15 set and bits 14:11 zero. The same read clears the held flags, so the status words return to 0x2000 and 0x4008 and the test word to 0x20.
- R4: A `rx_break` pulse loads 0x400 into the holding register and sets the same flags as a received byte. It does so even when a character is already held, and it replaces that character.
- R5: `irq` is high when status bit 9 and control bit 9 are both set. It is also high when status bit 13, control bit 13 and control bit 6 are all set. Otherwise it is low.
- R6: The first control word (0x20) stores and reads back all 32 bits. The interrupt follows a write from the next cycle.
- R7: Reading address 0x21 returns 1. Writing 0x21 with bit 0 at 0 returns every register except the first control word to its R1 value. Writing 0x21 with bit 0 at 1 changes nothing.
- R8: A write to the second status word clears only those bits written as 1 that lie in the mask 0xBDD6. Bits 14, 3 and 0 are unaffected.
- R9: A write to 0x10 drives `tx_valid` high for exactly one cycle, starting the cycle after the write, with `tx_byte` equal to the low 8 bits of the write data. Status bit 13 stays set.
- R10: A write to 0x29 stores the low 16 bits into the count register, which reads back at 0x2B; a read of 0x29 returns 0. A write to 0x2A stores the low 16 bits and reads back at 0x2A.
- R11: Reads of 0x22, 0x23, 0x24 and of any address without a register return 0. Writes to 0x25, 0x2D and unmapped addresses change no register.
- R12: `rdata` updates on the clock edge that samples `rd_en` and keeps that value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 8 | Word address |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| rx_byte | input | 8 | Received byte |
| rx_valid | input | 1 | Received byte is offered |
| rx_ready | output | 1 | Holding register can take a byte |
| rx_break | input | 1 | Line-break event pulse |
| tx_byte | output | 8 | Byte to transmit |
| tx_valid | output | 1 | One-cycle transmit strobe |
| irq | output | 1 | Level interrupt |

## Verification
Status and control effects of a write, read, accepted byte or break are due on the clock edge that samples the stimulus. Because `irq` and `rx_ready` are decoded from registers without a further stage, the bench checks them at the falling edge right after that edge. Read data is due one edge after `rd_en`. A monitor compares it at the following falling edge against a queue that the read task fills when it issues the strobe. `tx_valid` is due in the cycle after the write. A second monitor pops one expected byte for each falling edge where `tx_valid` is high, so a strobe that is missing, late or two cycles long shows up as a miscompare.

// File: rtl/sio_regfile_pkg.sv
package sio_regfile_pkg;

    // word addresses; software decodes these, so they stay fixed
    localparam int A_RXDATA = 'h00;
    localparam int A_TXDATA = 'h10;
    localparam int A_CTL1   = 'h20;
    localparam int A_CTL2   = 'h21;
    localparam int A_CTL3   = 'h22;
    localparam int A_CTL4   = 'h23;
    localparam int A_FIFOC  = 'h24;
    localparam int A_STAT1  = 'h25;
    localparam int A_STAT2  = 'h26;
    localparam int A_RSTEP  = 'h29;
    localparam int A_RMOD   = 'h2A;
    localparam int A_RCNT   = 'h2B;
    localparam int A_PROBE  = 'h2D;

    // bit positions used by the interrupt and status decode
    localparam int B_TXRDY   = 13;
    localparam int B_RXRDY   = 9;
    localparam int B_TXEMPEN = 6;
    localparam int B_RXEMPTY = 5;
    localparam int B_VALID   = 15;

    localparam int          HOLD_W   = 11;
    localparam int          BRK_CODE = 'h400;
    localparam logic [31:0] CTL1_RST = 32'h1;
    localparam logic [15:0] ST2_RST  = 16'h4008;
    localparam logic [15:0] ST2_W1C  = 16'hBDD6;

    typedef enum logic {
        HOLD_EMPTY = 1'b0,
        HOLD_FULL  = 1'b1
    } hold_state_e;

endpackage

// File: rtl/sio_rx_hold.sv
module sio_rx_hold
    import sio_regfile_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_clr,
    input  logic              take,
    input  logic [7:0]        char_in,
    input  logic              brk,
    input  logic              drain,
    output logic              full,
    output logic [HOLD_W-1:0] held
);

    hold_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            HOLD_EMPTY: begin
                if (!soft_clr && (brk || take)) state_d = HOLD_FULL;
            end
            HOLD_FULL: begin
                if (soft_clr)   state_d = HOLD_EMPTY;
                else if (brk)   state_d = HOLD_FULL;
                else if (drain) state_d = HOLD_EMPTY;
            end
            default: state_d = HOLD_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= HOLD_EMPTY;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        held <= '0;
        else if (soft_clr) held <= '0;
        else if (brk)      held <= HOLD_W'(BRK_CODE);
        else if (take)     held <= HOLD_W'(char_in);
    end

    assign full = (state_q == HOLD_FULL);

    // R3
    drain_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (drain && !brk && !take) |=> (state_q == HOLD_EMPTY));

    // R4
    break_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (brk && !soft_clr) |=> (held == HOLD_W'(BRK_CODE) && state_q == HOLD_FULL));

endmodule

// File: rtl/sio_tx_strobe.sv
module sio_tx_strobe (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       fire,
    input  logic [7:0] byte_in,
    output logic       tx_valid,
    output logic [7:0] tx_byte
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_valid <= 1'b0;
            tx_byte  <= '0;
        end else begin
            tx_valid <= fire;
            if (fire) tx_byte <= byte_in;
        end
    end

    // R9
    tx_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> (tx_valid && tx_byte == $past(byte_in)));

    // R9
    tx_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fire |=> !tx_valid);

endmodule

// File: rtl/sio_irq_gate.sv
module sio_irq_gate (
    input  logic rx_flag,
    input  logic tx_flag,
    input  logic en_rx,
    input  logic en_tx,
    input  logic en_empty,
    output logic irq
);

    logic rx_term, tx_term;

    always_comb begin
        rx_term = rx_flag & en_rx;
        tx_term = tx_flag & en_tx & en_empty;
        irq     = rx_term | tx_term;
    end

endmodule

// File: rtl/sio_regfile.sv
module sio_regfile
    import sio_regfile_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int RATE_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic [7:0]        rx_byte,
    input  logic              rx_valid,
    output logic              rx_ready,
    input  logic              rx_break,
    output logic [7:0]        tx_byte,
    output logic              tx_valid,
    output logic              irq
);

    localparam int PAD_W = B_VALID - HOLD_W;

    logic              wr_tx, wr_ctl1, wr_ctl2, wr_st2, wr_step, wr_mod, rd_rx;
    logic              soft_clr, take, full;
    logic [HOLD_W-1:0] held;
    logic [DATA_W-1:0] ctl1_q;
    logic [15:1]       st2_q;
    logic              txr_q;
    logic [RATE_W-1:0] rcnt_q, rmod_q;
    logic [DATA_W-1:0] stat1, stat2, probe, rd_val;

    // ---------------- address decode ----------------
    always_comb begin
        wr_tx   = wr_en && (addr == ADDR_W'(A_TXDATA));
        wr_ctl1 = wr_en && (addr == ADDR_W'(A_CTL1));
        wr_ctl2 = wr_en && (addr == ADDR_W'(A_CTL2));
        wr_st2  = wr_en && (addr == ADDR_W'(A_STAT2));
        wr_step = wr_en && (addr == ADDR_W'(A_RSTEP));
        wr_mod  = wr_en && (addr == ADDR_W'(A_RMOD));
        rd_rx   = rd_en && (addr == ADDR_W'(A_RXDATA));
        soft_clr = wr_ctl2 && !wdata[0];
        take     = rx_valid && !full;
    end

    assign rx_ready = !full;

    // ---------------- receive holding state machine ----------------
    sio_rx_hold u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_clr (soft_clr),
        .take     (take),
        .char_in  (rx_byte),
        .brk      (rx_break),
        .drain    (rd_rx),
        .full     (full),
        .held     (held)
    );

    // ---------------- transmit strobe ----------------
    sio_tx_strobe u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .fire     (wr_tx),
        .byte_in  (wdata[7:0]),
        .tx_valid (tx_valid),
        .tx_byte  (tx_byte)
    );

    // ---------------- control and status storage ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       ctl1_q <= CTL1_RST;
        else if (wr_ctl1) ctl1_q <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st2_q  <= ST2_RST[15:1];
            txr_q  <= 1'b1;
            rcnt_q <= '0;
            rmod_q <= '0;
        end else if (soft_clr) begin
            st2_q  <= ST2_RST[15:1];
            txr_q  <= 1'b1;
            rcnt_q <= '0;
            rmod_q <= '0;
        end else begin
            txr_q <= 1'b1;
            if (wr_st2)  st2_q  <= st2_q & ~(wdata[15:1] & ST2_W1C[15:1]);
            if (wr_step) rcnt_q <= wdata[RATE_W-1:0];
            if (wr_mod)  rmod_q <= wdata[RATE_W-1:0];
        end
    end

    // status words are views of the holding state plus stored bits
    always_comb begin
        stat1 = '0;
        stat1[B_TXRDY] = txr_q;
        stat1[B_RXRDY] = full;
        stat2 = DATA_W'({st2_q, full});
        probe = '0;
        probe[B_RXEMPTY] = !full;
    end

    // ---------------- interrupt ----------------
    sio_irq_gate u_irq (
        .rx_flag  (stat1[B_RXRDY]),
        .tx_flag  (stat1[B_TXRDY]),
        .en_rx    (ctl1_q[B_RXRDY]),
        .en_tx    (ctl1_q[B_TXRDY]),
        .en_empty (ctl1_q[B_TXEMPEN]),
        .irq      (irq)
    );

    // ---------------- read port ----------------
    always_comb begin
        rd_val = '0;
        case (addr)
            ADDR_W'(A_RXDATA): rd_val = DATA_W'({1'b1, {PAD_W{1'b0}}, held});
            ADDR_W'(A_CTL1):   rd_val = ctl1_q;
            ADDR_W'(A_CTL2):   rd_val = DATA_W'(1);
            ADDR_W'(A_STAT1):  rd_val = stat1;
            ADDR_W'(A_STAT2):  rd_val = stat2;
            ADDR_W'(A_RMOD):   rd_val = DATA_W'(rmod_q);
            ADDR_W'(A_RCNT):   rd_val = DATA_W'(rcnt_q);
            ADDR_W'(A_PROBE):  rd_val = probe;
            default:           rd_val = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     rdata <= '0;
        else if (rd_en) rdata <= rd_val;
    end

    // ---------------- assertions ----------------
    // R2
    accept_fills_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_ready && !soft_clr) |=> !rx_ready);

    // R5
    irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl1_q[B_RXRDY] && !ctl1_q[B_TXEMPEN]) |-> !irq);

    // R7
    ctl2_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == ADDR_W'(A_CTL2)) |=> (rdata == DATA_W'(1)));

    // R7
    soft_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        soft_clr |=> (rx_ready && rcnt_q == '0 && st2_q == ST2_RST[15:1]));

    // R12
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata));

endmodule

// File: tb/tb_sio_regfile.sv
`timescale 1ns/1ps
module tb_sio_regfile;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  addr = '0;
    logic        rd_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [7:0]  rx_byte = '0;
    logic        rx_valid = 1'b0;
    logic        rx_ready;
    logic        rx_break = 1'b0;
    logic [7:0]  tx_byte;
    logic        tx_valid;
    logic        irq;

    int vectors = 0;
    int miscompares = 0;
    logic [31:0] rexp_q[$];
    string       rtag_q[$];
    logic [7:0]  txexp_q[$];
    logic        rd_d = 1'b0;

    always #2.5 clk = ~clk;

    sio_regfile dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
        .wdata(wdata), .rdata(rdata), .rx_byte(rx_byte), .rx_valid(rx_valid),
        .rx_ready(rx_ready), .rx_break(rx_break), .tx_byte(tx_byte),
        .tx_valid(tx_valid), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    // read-data monitor: one result per issued read, due one edge later
    always @(posedge clk) rd_d <= rd_en;
    always @(negedge clk) begin
        if (rd_d) begin
            if (rexp_q.size() == 0) chk("R12 unexpected read", rdata, 32'hX);
            else chk(rtag_q.pop_front(), rdata, rexp_q.pop_front());
        end
    end

    // transmit monitor: one expected byte per cycle that tx_valid is high
    always @(negedge clk) begin
        if (rst_n && tx_valid) begin
            if (txexp_q.size() == 0) chk("R9 extra tx strobe", 32'(tx_byte), 32'hX);
            else chk("R9 tx byte", 32'(tx_byte), 32'(txexp_q.pop_front()));
        end
    end

    task automatic wr(input int a, input logic [31:0] d);
        addr = 8'(a); wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int a, input logic [31:0] e, input string tag);
        addr = 8'(a); rd_en = 1'b1;
        rexp_q.push_back(e); rtag_q.push_back(tag);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic send(input logic [7:0] b);
        rx_byte = b; rx_valid = 1'b1;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic brk();
        rx_break = 1'b1;
        @(negedge clk);
        rx_break = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        miscompares++;
        $display("FAIL all: watchdog expired, got hang expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 rx_ready", 32'(rx_ready), 1);
        chk("R1 irq", 32'(irq), 0);
        chk("R1 tx_valid", 32'(tx_valid), 0);
        rd('h20, 32'h1, "R1 control1");
        rd('h25, 32'h2000, "R1 status1");
        rd('h26, 32'h4008, "R1 status2");
        rd('h2D, 32'h20, "R1 test word");
        rd('h2A, 32'h0, "R1 modulator");
        rd('h2B, 32'h0, "R1 count");
        rd('h00, 32'h8000, "R1 R3 empty holder read");

        // R7 and R12: control2 reads 1 and the value is held
        rd('h21, 32'h1, "R7 control2 read");
        idle(2);
        chk("R12 rdata held", rdata, 32'h1);

        // R2 receive a byte
        send(8'h5A);
        chk("R2 rx_ready low when full", 32'(rx_ready), 0);
        rd('h25, 32'h2200, "R2 status1 full");
        rd('h26, 32'h4009, "R2 status2 full");
        rd('h2D, 32'h0, "R2 test word full");
        send(8'h33);
        // R3 the ignored byte must not replace the held one
        rd('h00, 32'h805A, "R3 read held byte");
        chk("R3 rx_ready after read", 32'(rx_ready), 1);
        rd('h25, 32'h2000, "R3 status1 cleared");
        rd('h26, 32'h4008, "R3 status2 cleared");
        rd('h2D, 32'h20, "R3 test word set");

        // R5 and R6 interrupt gating
        wr('h20, 32'h201);
        chk("R5 irq no data", 32'(irq), 0);
        send(8'hC3);
        chk("R5 irq receive", 32'(irq), 1);
        rd('h00, 32'h80C3, "R3 read C3");
        chk("R5 irq after drain", 32'(irq), 0);
        wr('h20, 32'h2001);
        chk("R5 tx ready without empty enable", 32'(irq), 0);
        wr('h20, 32'h2041);
        chk("R5 tx ready with empty enable", 32'(irq), 1);
        wr('h20, 32'h0041);
        chk("R5 empty enable alone", 32'(irq), 0);
        wr('h20, 32'hDEADBEEF);
        chk("R6 irq after full-word write", 32'(irq), 1);
        rd('h20, 32'hDEADBEEF, "R6 control1 readback");
        wr('h20, 32'h1);
        chk("R6 irq after restore", 32'(irq), 0);

        // R4 break, on empty and over a held byte
        brk();
        chk("R4 rx_ready after break", 32'(rx_ready), 0);
        rd('h26, 32'h4009, "R4 status2 after break");
        rd('h00, 32'h8400, "R4 break code");
        send(8'h11);
        brk();
        rd('h00, 32'h8400, "R4 break overwrites");

        // R8 write-one-to-clear mask, R11 ignored writes
        send(8'h77);
        wr('h26, 32'hFFFFFFFF);
        rd('h26, 32'h4009, "R8 unmasked bits kept");
        wr('h25, 32'h0);
        rd('h25, 32'h2200, "R11 status1 write ignored");
        wr('h2D, 32'hFF);
        rd('h2D, 32'h0, "R11 test word write ignored");
        wr('h30, 32'hFFFFFFFF);
        rd('h20, 32'h1, "R11 unmapped write ignored");
        rd('h00, 32'h8077, "R3 read 77");

        // R10 rate registers
        wr('h29, 32'h1234);
        rd('h2B, 32'h1234, "R10 count from increment write");
        rd('h29, 32'h0, "R10 increment reads zero");
        wr('h2A, 32'h12345);
        rd('h2A, 32'h2345, "R10 modulator low bits");

        // R11 zero reads
        rd('h22, 32'h0, "R11 control3");
        rd('h23, 32'h0, "R11 control4");
        rd('h24, 32'h0, "R11 fifo control");
        rd('h3F, 32'h0, "R11 unmapped");

        // R9 transmit
        txexp_q.push_back(8'hA7);
        wr('h10, 32'h1A7);
        idle(1);
        chk("R9 strobe ended", 32'(tx_valid), 0);
        rd('h25, 32'h2000, "R9 tx ready kept");

        // R7 soft reset
        wr('h20, 32'h41);
        send(8'h99);
        wr('h21, 32'h1);
        rd('h25, 32'h2200, "R7 bit0 high no reset");
        wr('h21, 32'h0);
        chk("R7 rx_ready after soft reset", 32'(rx_ready), 1);
        rd('h25, 32'h2000, "R7 status1 reset");
        rd('h26, 32'h4008, "R7 status2 reset");
        rd('h2D, 32'h20, "R7 test word reset");
        rd('h2B, 32'h0, "R7 count reset");
        rd('h2A, 32'h0, "R7 modulator reset");
        rd('h00, 32'h8000, "R7 holder reset");
        rd('h20, 32'h41, "R7 control1 kept");

        idle(2);
        chk("R12 read queue drained", 32'(rexp_q.size()), 0);
        chk("R9 tx queue drained", 32'(txexp_q.size()), 0);
        finish_run();
    end

endmodule